// File: doc/BRIEF.md
# Multichannel Acquisition Scan Sequencer

This block steps a shared sample-hold and converter across sixteen analog inputs. It drives the select lines of an external analog multiplexer and moves on through the channels in a fixed circular order. On each channel it lets the input settle for a programmable time, then fires a one-clock start-of-conversion pulse. It waits for the converter's active-low done signal, pulls the active-low read strobe for a programmable number of clocks, and captures the result.

Each 16-bit result goes into a dual-port buffer memory as two bytes. Every channel owns a fixed 1K-byte window of that memory and fills it in successive locations. When a window fills, its write offset wraps to zero and a per-channel full flag is raised. A host reads the flags and clears them. A synchronous run input lets the host pause the scan. A pause only ever takes effect on a channel boundary.

Top module: `acq_scan_seq`

## Requirements
- R1: While reset is asserted and after it is released with run low, the outputs are: mux select 0, start-of-conversion low, read strobe high, buffer write-enable high, buffer address 0, and all full flags 0.
- R2: Conversions visit the channels in the order 0, 1, …, 15, 0, …. Each start-of-conversion is issued while the mux select shows the channel whose result is written next.
- R3: Start-of-conversion is high for exactly one clock. In continuous scanning it rises after the new mux select has been held for exactly settle_len+1 clocks. The mux select never changes during that wait.
- R4: The read strobe falls in the clock after the first edge that samples end-of-conversion low. It stays low for rd_len clocks, with a value of 0 acting as 1. The result is latched on its last low clock.
- R5: The byte address is {channel[3:0], offset[9:0]}. The offset is twice the channel's sample count modulo 512, plus the byte index. The low byte (bits 7:0) of a result is written first, at the even address, and the high byte follows at the odd address.
- R6: Buffer write-enable is low for exactly one clock per byte. Address and data hold the same values in the clock before and the clock after that low clock.
- R7: When a channel stores its 512th sample since its offset was last zero, its offset returns to 0 and its full flag goes high one clock after the high-byte write.
- R8: A high bit on full_clr clears the matching full flag at the next edge and leaves the other flags unchanged. If a channel sets its flag on the same edge, the set wins.
- R9: Dropping run never cuts a transaction short. The block finishes the transaction in progress, both byte writes included, and then stops with the mux select showing the next channel. When run returns, scanning resumes from that channel.
- R10: A reset in the middle of a scan returns the channel to 0 and every window offset to 0. The first write after release goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan enable, sampled at channel boundaries |
| settle_len | input | SET_W | Settling clocks after a channel change, minus one |
| rd_len | input | RD_W | Read strobe length in clocks (0 acts as 1) |
| mux_sel | output | CH_W | Analog multiplexer channel select |
| adc_soc | output | 1 | Start-of-conversion pulse |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_data | input | SMP_W | Converter result |
| buf_addr | output | ADDR_W | Buffer byte address {channel, offset} |
| buf_data | output | SMP_W/2 | Buffer write byte |
| buf_we_n | output | 1 | Buffer write-enable, active low |
| full_clr | input | NCH | Per-channel full flag clear |
| full_flags | output | NCH | Per-channel window-full flags |

## Verification
The assertions rely on the following converter behaviour:
- End-of-conversion is lowered only after a start pulse.
- The result stays stable from that point until the read strobe ends.
- End-of-conversion goes back high once the read strobe has been seen.

The bench converter model keeps to this contract. It drops end-of-conversion three clocks after each start and raises it on the first read-strobe clock. It tags every result with the channel and that channel's conversion count.

The bench changes settle_len and rd_len only while the scan is stopped, because the timing checks assume both are steady within a transaction. Host clears are one-clock pulses, including one placed on the clock where a window wraps.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;

    // Channel transaction phases
    typedef enum logic [2:0] {
        CS_IDLE   = 3'd0,
        CS_SETTLE = 3'd1,
        CS_SOC    = 3'd2,
        CS_WAIT   = 3'd3,
        CS_READ   = 3'd4,
        CS_WRITE  = 3'd5,
        CS_NEXT   = 3'd6
    } ctrl_st_e;

    // Per-byte buffer write phases
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_SETUP  = 2'd1,
        WS_STROBE = 2'd2,
        WS_HOLD   = 2'd3
    } wr_st_e;

endpackage

// File: rtl/acq_scan_ctrl.sv
module acq_scan_ctrl
    import acq_scan_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int CH_W  = 4,
    parameter int SMP_W = 16,
    parameter int SET_W = 8,
    parameter int RD_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic [RD_W-1:0]  rd_len_i,
    input  logic             eoc_n_i,
    input  logic [SMP_W-1:0] adc_data_i,
    input  logic             wr_done_i,
    output logic [CH_W-1:0]  chan_o,
    output logic             soc_o,
    output logic             rd_n_o,
    output logic             wr_req_o,
    output logic [SMP_W-1:0] sample_o
);

    localparam int CNT_W = (SET_W > RD_W) ? SET_W : RD_W;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    typedef struct packed {
        ctrl_st_e           st;
        logic [CH_W-1:0]    chan;
        logic [CNT_W-1:0]   cnt;
        logic [SMP_W-1:0]   smp;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            CS_IDLE: begin
                if (run_i) begin
                    d.st  = CS_SETTLE;
                    d.cnt = CNT_W'(settle_i);
                end
            end
            CS_SETTLE: begin
                if (q.cnt == '0) d.st = CS_SOC;
                else             d.cnt = q.cnt - 1'b1;
            end
            CS_SOC: d.st = CS_WAIT;
            CS_WAIT: begin
                if (!eoc_n_i) begin
                    d.st  = CS_READ;
                    d.cnt = (rd_len_i == '0) ? '0 : CNT_W'(rd_len_i - 1'b1);
                end
            end
            CS_READ: begin
                if (q.cnt == '0) begin
                    d.smp = adc_data_i;
                    d.st  = CS_WRITE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            CS_WRITE: begin
                if (wr_done_i) d.st = CS_NEXT;
            end
            CS_NEXT: begin
                d.chan = (q.chan == LAST_CH) ? '0 : q.chan + 1'b1;
                if (run_i) begin
                    d.st  = CS_SETTLE;
                    d.cnt = CNT_W'(settle_i);
                end else begin
                    d.st = CS_IDLE;
                end
            end
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign chan_o   = q.chan;
    assign soc_o    = (q.st == CS_SOC);
    assign rd_n_o   = (q.st != CS_READ);
    assign wr_req_o = (q.st == CS_WRITE);
    assign sample_o = q.smp;

    // R3
    soc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |=> !soc_o);

    // R3
    soc_mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |-> $stable(chan_o));

    // R2
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_o != $past(chan_o)) |->
        (chan_o == (($past(chan_o) == LAST_CH) ? CH_W'(0) : CH_W'($past(chan_o) + 1'b1))));

    // R4
    rd_after_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(!eoc_n_i));

endmodule

// File: rtl/acq_win_addr.sv
module acq_win_addr #(
    parameter int NCH    = 16,
    parameter int CH_W   = 4,
    parameter int SIDX_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CH_W-1:0]        chan_i,
    input  logic                   commit_i,
    input  logic [NCH-1:0]         clr_i,
    output logic [CH_W+SIDX_W-1:0] word_addr_o,
    output logic [NCH-1:0]         full_o
);

    typedef struct packed {
        logic [NCH-1:0][SIDX_W-1:0] idx;
        logic [NCH-1:0]             full;
    } win_t;

    win_t d, q;

    always_comb begin
        d = q;
        for (int i = 0; i < NCH; i++) begin
            if (clr_i[i]) d.full[i] = 1'b0;
            if (commit_i && (chan_i == CH_W'(i))) begin
                d.idx[i] = q.idx[i] + 1'b1;
                if (&q.idx[i]) d.full[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_addr_o = {chan_i, q.idx[chan_i]};
    assign full_o      = q.full;

    for (genvar g = 0; g < NCH; g++) begin : g_flag_chk
        // R7
        full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(full_o[g]) |-> ($past(commit_i) && ($past(chan_i) == CH_W'(g))));

        // R8
        full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !(commit_i && (chan_i == CH_W'(g)))) |=> !full_o[g]);
    end

endmodule

// File: rtl/acq_byte_wr.sv
module acq_byte_wr
    import acq_scan_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [ADDR_W-2:0]   word_addr_i,
    input  logic [2*BYTE_W-1:0] word_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [BYTE_W-1:0]   data_o,
    output logic                we_n_o,
    output logic                done_o
);

    typedef struct packed {
        wr_st_e             st;
        logic               hi;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  data;
    } wr_t;

    wr_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            WS_IDLE: begin
                if (req_i) begin
                    d.st   = WS_SETUP;
                    d.hi   = 1'b0;
                    d.addr = {word_addr_i, 1'b0};
                    d.data = word_i[BYTE_W-1:0];
                end
            end
            WS_SETUP:  d.st = WS_STROBE;
            WS_STROBE: d.st = WS_HOLD;
            WS_HOLD: begin
                if (q.hi) begin
                    d.st = WS_IDLE;
                end else begin
                    d.st   = WS_SETUP;
                    d.hi   = 1'b1;
                    d.addr = {word_addr_i, 1'b1};
                    d.data = word_i[2*BYTE_W-1:BYTE_W];
                end
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_o = q.addr;
    assign data_o = q.data;
    assign we_n_o = (q.st != WS_STROBE);
    assign done_o = (q.st == WS_HOLD) && q.hi;

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |=> we_n_o);

    // R6
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |-> ($stable(addr_o) && $stable(data_o)));

    // R6
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> ($stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq #(
    parameter int NCH       = 16,
    parameter int WIN_BYTES = 1024,
    parameter int SMP_W     = 16,
    parameter int SET_W     = 8,
    parameter int RD_W      = 4,
    localparam int CH_W     = $clog2(NCH),
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int ADDR_W   = CH_W + OFF_W,
    localparam int BYTE_W   = SMP_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [SET_W-1:0]  settle_len,
    input  logic [RD_W-1:0]   rd_len,
    output logic [CH_W-1:0]   mux_sel,
    output logic              adc_soc,
    input  logic              adc_eoc_n,
    output logic              adc_rd_n,
    input  logic [SMP_W-1:0]  adc_data,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_data,
    output logic              buf_we_n,
    input  logic [NCH-1:0]    full_clr,
    output logic [NCH-1:0]    full_flags
);

    localparam int SIDX_W = OFF_W - 1;

    logic              wr_req;
    logic              wr_done;
    logic [SMP_W-1:0]  sample;
    logic [ADDR_W-2:0] word_addr;

    acq_scan_ctrl #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .SMP_W (SMP_W),
        .SET_W (SET_W),
        .RD_W  (RD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .settle_i   (settle_len),
        .rd_len_i   (rd_len),
        .eoc_n_i    (adc_eoc_n),
        .adc_data_i (adc_data),
        .wr_done_i  (wr_done),
        .chan_o     (mux_sel),
        .soc_o      (adc_soc),
        .rd_n_o     (adc_rd_n),
        .wr_req_o   (wr_req),
        .sample_o   (sample)
    );

    acq_win_addr #(
        .NCH    (NCH),
        .CH_W   (CH_W),
        .SIDX_W (SIDX_W)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_i      (mux_sel),
        .commit_i    (wr_done),
        .clr_i       (full_clr),
        .word_addr_o (word_addr),
        .full_o      (full_flags)
    );

    acq_byte_wr #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (wr_req),
        .word_addr_i (word_addr),
        .word_i      (sample),
        .addr_o      (buf_addr),
        .data_o      (buf_data),
        .we_n_o      (buf_we_n),
        .done_o      (wr_done)
    );

    // R5
    wr_chan_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_we_n |-> (buf_addr[ADDR_W-1 -: CH_W] == mux_sel));

endmodule

// File: tb/acq_scan_seq_tb.sv
module acq_scan_seq_tb;

    localparam int NCH   = 16;
    localparam int WIN   = 16;
    localparam int SPW   = WIN / 2;
    localparam int SET_W = 4;
    localparam int RD_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic [SET_W-1:0] settle_len = '0;
    logic [RD_W-1:0]  rd_len = '0;
    logic [3:0]       mux_sel;
    logic             adc_soc;
    logic             adc_eoc_n = 1'b1;
    logic             adc_rd_n;
    logic [15:0]      adc_data = '0;
    logic [7:0]       buf_addr;
    logic [7:0]       buf_data;
    logic             buf_we_n;
    logic [15:0]      full_clr = '0;
    logic [15:0]      full_flags;

    acq_scan_seq #(
        .NCH(NCH), .WIN_BYTES(WIN), .SMP_W(16), .SET_W(SET_W), .RD_W(RD_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .settle_len(settle_len),
        .rd_len(rd_len), .mux_sel(mux_sel), .adc_soc(adc_soc),
        .adc_eoc_n(adc_eoc_n), .adc_rd_n(adc_rd_n), .adc_data(adc_data),
        .buf_addr(buf_addr), .buf_data(buf_data), .buf_we_n(buf_we_n),
        .full_clr(full_clr), .full_flags(full_flags)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor and converter model state
    int         phase_id = 0;
    int         seen_phase = -1;
    int         soc_in_phase = 0;
    int         since = 0;
    logic [3:0] last_mux = '0;
    bit         prev_soc = 0;
    bit         prev_eoc = 1;
    int         rd_run = 0;
    bit         prev_we_n = 1;
    logic [7:0] prev_addr = '0;
    logic [7:0] prev_data = '0;
    bit         prev_hi = 0;
    bit         wr_hi = 0;
    logic [3:0] exp_ch = '0;
    logic [3:0] exp_soc_ch = '0;
    int         exp_n [16];
    logic [15:0] exp_full = '0;
    bit         cmt_due = 0;
    bit         cmt_wrap = 0;
    logic [3:0] cmt_ch = '0;
    int         txn = 0;
    bit         conv_busy = 0;
    int         conv_lat = 0;
    logic [3:0] conv_ch = '0;
    int         conv_cnt [16];

    always @(negedge clk) begin
        if (!rst_n) begin
            since = 0; last_mux = '0; prev_soc = 0; prev_eoc = 1; rd_run = 0;
            prev_we_n = 1; prev_addr = '0; prev_data = '0; prev_hi = 0; wr_hi = 0;
            exp_ch = '0; exp_soc_ch = '0; exp_full = '0; cmt_due = 0;
            soc_in_phase = 0; conv_busy = 0; conv_lat = 0;
            for (int i = 0; i < 16; i++) begin exp_n[i] = 0; conv_cnt[i] = 0; end
            adc_eoc_n <= 1'b1;
        end else begin
            int  exp_rd;
            bit  cur_hi;
            logic [15:0] word;
            logic [7:0]  ea, ed;
            if (phase_id != seen_phase) begin seen_phase = phase_id; soc_in_phase = 0; end
            // R2 / R3: channel order and settling
            if (mux_sel != last_mux) since = 0;
            if (prev_soc) chk(!adc_soc, "R3", "soc width", adc_soc, 0);
            if (adc_soc) begin
                chk(mux_sel == exp_soc_ch, "R2", "soc channel", mux_sel, exp_soc_ch);
                if (soc_in_phase > 0)
                    chk(since == settle_len + 1, "R3", "settle cycles", since, settle_len + 1);
                else
                    chk(since >= settle_len + 1, "R3", "settle cycles min", since, settle_len + 1);
                exp_soc_ch = exp_soc_ch + 1'b1;
                soc_in_phase++;
            end
            since++;
            last_mux = mux_sel;
            prev_soc = adc_soc;
            // R4: read strobe
            exp_rd = (rd_len == 0) ? 1 : int'(rd_len);
            if (!adc_rd_n) begin
                if (rd_run == 0)
                    chk(!adc_eoc_n && prev_eoc, "R4", "read strobe start", adc_eoc_n, 0);
                rd_run++;
            end else if (rd_run > 0) begin
                chk(rd_run == exp_rd, "R4", "read strobe length", rd_run, exp_rd);
                rd_run = 0;
            end
            // R7 / R8: expected flags, clear before set
            exp_full = exp_full & ~full_clr;
            if (cmt_due) begin
                if (cmt_wrap) exp_full[cmt_ch] = 1'b1;
                cmt_due = 0;
            end
            // R6: hold after strobe
            if (!prev_we_n) begin
                chk(buf_we_n && buf_addr == prev_addr && buf_data == prev_data,
                    "R6", "hold after strobe", buf_addr, prev_addr);
                if (prev_hi) cmt_due = 1;
            end
            cur_hi = 0;
            if (!buf_we_n) begin
                chk(prev_we_n && buf_addr == prev_addr && buf_data == prev_data,
                    "R6", "setup before strobe", buf_addr, prev_addr);
                word = {exp_ch, 12'(exp_n[exp_ch])};
                ea   = {exp_ch, 3'(exp_n[exp_ch] % SPW), wr_hi};
                ed   = wr_hi ? word[15:8] : word[7:0];
                chk(buf_addr == ea, "R5", "byte address", buf_addr, ea);
                chk(buf_data == ed, "R5", "byte data", buf_data, ed);
                cur_hi = wr_hi;
                if (wr_hi) begin
                    cmt_ch = exp_ch;
                    exp_n[exp_ch]++;
                    cmt_wrap = (exp_n[exp_ch] % SPW) == 0;
                    exp_ch = exp_ch + 1'b1;
                    txn++;
                end
                wr_hi = !wr_hi;
            end
            chk(full_flags == exp_full, "R7/R8", "full flags", full_flags, exp_full);
            prev_we_n = buf_we_n; prev_addr = buf_addr; prev_data = buf_data; prev_hi = cur_hi;
            prev_eoc = adc_eoc_n;
            // converter model
            if (!adc_rd_n) adc_eoc_n <= 1'b1;
            if (adc_soc) begin
                conv_busy = 1; conv_lat = 2; conv_ch = mux_sel;
            end else if (conv_busy) begin
                if (conv_lat > 0) conv_lat--;
                else begin
                    adc_eoc_n <= 1'b0;
                    adc_data  <= {conv_ch, 12'(conv_cnt[conv_ch])};
                    conv_cnt[conv_ch]++;
                    conv_busy = 0;
                end
            end
        end
    end

    task automatic wait_txn(input int n);
        int t0 = txn;
        for (int k = 0; k < 20000 && txn < t0 + n; k++) @(negedge clk);
    endtask

    task automatic stop_and_check(input string tag);
        int t1;
        run <= 1'b0;
        repeat (120) @(negedge clk);
        t1 = txn;
        repeat (40) @(negedge clk);
        chk(txn == t1, "R9", {tag, " no writes while stopped"}, txn, t1);
        chk(mux_sel == exp_ch, "R9", {tag, " parked on next channel"}, mux_sel, exp_ch);
        chk(!adc_soc && adc_rd_n && buf_we_n, "R9", {tag, " strobes idle"}, buf_we_n, 1);
    endtask

    task automatic check_reset_outputs(input string req);
        chk(mux_sel == 0, req, "mux select", mux_sel, 0);
        chk(adc_soc == 0, req, "soc", adc_soc, 0);
        chk(adc_rd_n == 1, req, "read strobe", adc_rd_n, 1);
        chk(buf_we_n == 1, req, "write enable", buf_we_n, 1);
        chk(buf_addr == 0, req, "address", buf_addr, 0);
        chk(full_flags == 0, req, "full flags", full_flags, 0);
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        int settles [3] = '{0, 3, 15};
        int reads   [3] = '{0, 1, 4};
        repeat (5) @(negedge clk);
        check_reset_outputs("R1");
        rst_n <= 1'b1;
        repeat (10) @(negedge clk);
        check_reset_outputs("R1");

        // Sweep settle and read lengths
        foreach (settles[si]) begin
            foreach (reads[ri]) begin
                phase_id   <= phase_id + 1;
                settle_len <= SET_W'(settles[si]);
                rd_len     <= RD_W'(reads[ri]);
                @(negedge clk);
                run <= 1'b1;
                wait_txn(15);
                stop_and_check("sweep");
            end
        end
        chk(full_flags == 16'hFFFF, "R7", "all windows wrapped", full_flags, 16'hFFFF);

        // R8: host clear of a subset, then the rest
        full_clr <= 16'h00FF;
        @(negedge clk);
        full_clr <= '0;
        @(negedge clk);
        chk(full_flags == 16'hFF00, "R8", "partial clear", full_flags, 16'hFF00);
        full_clr <= 16'hFF00;
        @(negedge clk);
        full_clr <= '0;
        @(negedge clk);
        chk(full_flags == 16'h0000, "R8", "remaining clear", full_flags, 0);

        // R8: clear on the same edge as a wrap, set wins
        phase_id <= phase_id + 1;
        settle_len <= 4'd1;
        rd_len <= 3'd2;
        @(negedge clk);
        run <= 1'b1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!buf_we_n && buf_addr[0] && buf_addr[3:1] == 3'd7) begin
                logic [3:0] c;
                c = buf_addr[7:4];
                @(negedge clk);
                full_clr <= 16'(1) << c;
                @(negedge clk);
                full_clr <= '0;
                chk(full_flags[c] == 1'b1, "R8", "set wins over clear", full_flags[c], 1);
                break;
            end
        end
        stop_and_check("race");

        // R9: stop right after a start pulse
        phase_id <= phase_id + 1;
        @(negedge clk);
        run <= 1'b1;
        for (int k = 0; k < 2000 && !adc_soc; k++) @(negedge clk);
        begin
            int t0;
            logic [3:0] ch;
            t0 = txn;
            ch = mux_sel;
            run <= 1'b0;
            repeat (120) @(negedge clk);
            chk(txn == t0 + 1, "R9", "in-flight transaction completes", txn, t0 + 1);
            chk(mux_sel == ch + 4'd1, "R9", "stopped on next channel", mux_sel, ch + 4'd1);
        end
        stop_and_check("midstop");
        phase_id <= phase_id + 1;
        @(negedge clk);
        run <= 1'b1;
        wait_txn(3);
        stop_and_check("resume");

        // R10: reset in the middle of a transaction
        phase_id <= phase_id + 1;
        @(negedge clk);
        run <= 1'b1;
        wait_txn(5);
        for (int k = 0; k < 2000 && adc_rd_n; k++) @(negedge clk);
        rst_n <= 1'b0;
        repeat (3) @(negedge clk);
        check_reset_outputs("R10");
        rst_n <= 1'b1;
        for (int k = 0; k < 2000 && buf_we_n; k++) @(negedge clk);
        chk(buf_addr == 0, "R10", "first write after reset", buf_addr, 0);
        wait_txn(20);
        stop_and_check("post-reset");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule